// File: doc/BRIEF.md
# Two-Level Branch Direction Predictor with Return Stack

This block sits in the fetch stage and decides where fetch goes next. Each cycle it looks up the current fetch address in a direct-mapped branch target buffer. Each buffer entry holds a tag, a target, a branch kind and the last four resolved outcomes of that branch. For a conditional branch, that 4-bit local history selects one 2-bit saturating counter in a shared pattern table, and the counter's upper bit gives the direction. Calls, returns and unconditional jumps that hit are always taken. A hit on a call pushes the address of the next sequential instruction onto an eight-entry return stack. A hit on a return takes its target from the top of that stack, or from the buffer when the stack is empty. A taken prediction from the buffer is flagged as costing one bubble before the redirected fetch.

When decode finds a branch that the buffer does not hold, the block applies a fixed rule: a target below the branch address means taken, and any other target means not taken. A taken static prediction is raised as a late redirect, with roughly a six-cycle cost. Resolved branches come back on an update port. An update shifts the real outcome into the entry's history and trains the counter that the current history selects. A miss gets a new entry only when the branch resolved taken.

Top module: `bpred_fetch`

## Requirements
- R1: After reset no fetch address hits. A fetch that misses gives pred_taken=0, pred_bubble=0 and pred_target = fetch_pc + 4.
- R2: A resolved not-taken branch that misses the buffer creates no entry. A resolved taken branch creates an entry, so the next fetch of that address hits.
- R3: A newly allocated conditional entry has history 0001. Every pattern counter resets to weakly not-taken (01). A fetch hit on a conditional branch predicts taken exactly when the selected counter is 10 or 11. So the first fetch after allocation predicts not taken, with target fetch_pc + 4.
- R4: Each conditional update trains the counter that the entry's history selects before the shift, then shifts the outcome in at bit 0. After allocation plus four taken updates, the fetch predicts taken, targets the stored address and asserts pred_bubble. One following not-taken update makes the next prediction not taken.
- R5: A decode report of a branch that misses the buffer asserts late_static. late_redirect and late_taken are asserted exactly when dec_target < dec_pc, and late_target is then dec_target; otherwise late_target is dec_pc + 4. A decode report that hits asserts none of these flags.
- R6: The buffer is direct-mapped on fetch_pc[7:2] and checks the remaining upper bits as a tag. A different address with the same index misses, and a new allocation replaces the previous entry.
- R7: A fetch hit on a call entry pushes fetch_pc + 4. A fetch hit on a return entry with a non-empty stack predicts that address and pops it, asserting pred_from_ras. After more than eight pushes the stack keeps the newest eight, and they pop newest first.
- R8: A fetch hit on a return entry with an empty stack predicts the target stored in the buffer, with pred_from_ras=0.
- R9: Kind encoding is 00 conditional, 01 call, 10 return, 11 jump. A fetch hit on a non-conditional kind always predicts taken, whatever the counters hold. A not-taken update of such an entry keeps its stored target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_valid | input | 1 | Fetch address is consumed this cycle (enables stack push/pop) |
| fetch_pc | input | 32 | Current fetch address |
| pred_hit | output | 1 | Fetch address hit the buffer |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | 32 | Next fetch address |
| pred_bubble | output | 1 | Taken buffer prediction, one bubble before redirected fetch |
| pred_from_ras | output | 1 | Target came from the return stack |
| dec_valid | input | 1 | Decode reports a branch |
| dec_pc | input | 32 | Address of the decoded branch |
| dec_target | input | 32 | Decoded branch target |
| late_static | output | 1 | Decoded branch missed the buffer, static rule applied |
| late_taken | output | 1 | Static rule predicts taken |
| late_redirect | output | 1 | Late redirect to late_target is required |
| late_target | output | 32 | Address chosen by the static rule |
| upd_valid | input | 1 | Resolved branch update |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_kind | input | 2 | Branch kind (00 cond, 01 call, 10 return, 11 jump) |
| upd_target | input | 32 | Actual target |

## Verification
Fetch and decode outputs are combinational from the current state, so they are due in the cycle their inputs are applied. The bench drives inputs just after a falling edge and compares one time unit later, before the next rising edge. An update, and a push or pop from a consumed fetch, takes effect at the next rising edge. For that reason the bench only looks at its effect on a fetch applied at the following falling edge. After reset the internal two-stage release must pass, so the bench waits several cycles before the first compare.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  typedef enum logic [1:0] {
    K_COND = 2'b00,
    K_CALL = 2'b01,
    K_RET  = 2'b10,
    K_JUMP = 2'b11
  } br_kind_e;

  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
    logic [1:0] r;
    if (up) r = (c == 2'b11) ? c : c + 2'b01;
    else    r = (c == 2'b00) ? c : c - 2'b01;
    return r;
  endfunction

endpackage

// File: rtl/bpred_btb.sv
module bpred_btb
  import bpred_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int ENTRIES    = 64,
  parameter int HIST_W     = 4,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   f_pc,
  output logic              f_hit,
  output logic [PC_W-1:0]   f_target,
  output logic [HIST_W-1:0] f_hist,
  output br_kind_e          f_kind,
  input  logic [PC_W-1:0]   d_pc,
  output logic              d_hit,
  input  logic              u_valid,
  input  logic [PC_W-1:0]   u_pc,
  input  logic              u_taken,
  input  br_kind_e          u_kind,
  input  logic [PC_W-1:0]   u_target,
  output logic              u_hit,
  output logic [HIST_W-1:0] u_hist
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int OFF_W = $clog2(INSN_BYTES);
  localparam int TAG_W = PC_W - IDX_W - OFF_W;

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [PC_W-1:0]    tgt_q  [ENTRIES];
  logic [HIST_W-1:0]  hist_q [ENTRIES];
  br_kind_e           kind_q [ENTRIES];

  logic [IDX_W-1:0] f_idx, d_idx, u_idx;
  logic [TAG_W-1:0] f_tag, d_tag, u_tag;

  assign f_idx = f_pc[OFF_W +: IDX_W];
  assign d_idx = d_pc[OFF_W +: IDX_W];
  assign u_idx = u_pc[OFF_W +: IDX_W];
  assign f_tag = f_pc[PC_W-1 -: TAG_W];
  assign d_tag = d_pc[PC_W-1 -: TAG_W];
  assign u_tag = u_pc[PC_W-1 -: TAG_W];

  logic unused_low;
  assign unused_low = ^{f_pc[OFF_W-1:0], d_pc[OFF_W-1:0], u_pc[OFF_W-1:0]};

  // lookups
  assign f_hit    = valid_q[f_idx] && (tag_q[f_idx] == f_tag);
  assign f_target = tgt_q[f_idx];
  assign f_hist   = hist_q[f_idx];
  assign f_kind   = kind_q[f_idx];
  assign d_hit    = valid_q[d_idx] && (tag_q[d_idx] == d_tag);
  assign u_hit    = valid_q[u_idx] && (tag_q[u_idx] == u_tag);
  assign u_hist   = hist_q[u_idx];

  // write side: train a hit, allocate only on a taken miss
  logic              wr_en;
  logic [PC_W-1:0]   wr_tgt;
  logic [HIST_W-1:0] wr_hist;
  logic [HIST_W-1:0] hist_base;

  always_comb begin
    wr_en     = u_valid && (u_hit || u_taken);
    hist_base = u_hit ? hist_q[u_idx] : '0;
    wr_hist   = {hist_base[HIST_W-2:0], u_taken};
    wr_tgt    = u_taken ? u_target : tgt_q[u_idx];
    valid_d   = valid_q;
    if (wr_en) valid_d[u_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[u_idx]  <= u_tag;
      tgt_q[u_idx]  <= wr_tgt;
      hist_q[u_idx] <= wr_hist;
      kind_q[u_idx] <= u_kind;
    end
  end

endmodule

// File: rtl/bpred_pht.sv
module bpred_pht
  import bpred_pkg::*;
#(
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] rd_idx,
  output logic              rd_taken,
  input  logic              wr_en,
  input  logic [HIST_W-1:0] wr_idx,
  input  logic              wr_taken
);

  localparam int N_CTR = 1 << HIST_W;

  logic [N_CTR-1:0] ctr_msb;

  for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
    logic [1:0] c_q, c_d;
    logic       sel;

    assign sel = wr_en && (wr_idx == HIST_W'(i));

    always_comb begin
      c_d = c_q;
      if (sel) c_d = ctr_step(c_q, wr_taken);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) c_q <= 2'b01;
      else        c_q <= c_d;
    end

    assign ctr_msb[i] = c_q[1];
  end

  assign rd_taken = ctr_msb[rd_idx];

endmodule

// File: rtl/bpred_ras.sv
module bpred_ras #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [PC_W-1:0] push_addr,
  input  logic            pop,
  output logic            top_valid,
  output logic [PC_W-1:0] top_addr
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PC_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign top_valid = (cnt_q != '0);
  assign top_addr  = mem[ptr_q - PTR_W'(1)];

  always_comb begin
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    if (push) begin
      ptr_d = ptr_q + PTR_W'(1);
      if (cnt_q != CNT_W'(DEPTH)) cnt_d = cnt_q + CNT_W'(1);
    end else if (pop && top_valid) begin
      ptr_d = ptr_q - PTR_W'(1);
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[ptr_q] <= push_addr;
  end

endmodule

// File: rtl/bpred_fetch.sv
module bpred_fetch
  import bpred_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int BTB_ENTRIES = 64,
  parameter int HIST_W      = 4,
  parameter int RAS_DEPTH   = 8,
  parameter int INSN_BYTES  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_target,
  output logic            pred_bubble,
  output logic            pred_from_ras,
  input  logic            dec_valid,
  input  logic [PC_W-1:0] dec_pc,
  input  logic [PC_W-1:0] dec_target,
  output logic            late_static,
  output logic            late_taken,
  output logic            late_redirect,
  output logic [PC_W-1:0] late_target,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [1:0]      upd_kind,
  input  logic [PC_W-1:0] upd_target
);

  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              f_hit, d_hit, u_hit;
  logic [PC_W-1:0]   f_tgt;
  logic [HIST_W-1:0] f_hist, u_hist;
  br_kind_e          f_kind, u_kind_e;
  logic              ctr_taken;
  logic              ras_valid;
  logic [PC_W-1:0]   ras_top;

  assign u_kind_e = br_kind_e'(upd_kind);

  bpred_btb #(
    .PC_W(PC_W), .ENTRIES(BTB_ENTRIES), .HIST_W(HIST_W), .INSN_BYTES(INSN_BYTES)
  ) u_btb (
    .clk(clk), .rst_n(rst_int_n),
    .f_pc(fetch_pc), .f_hit(f_hit), .f_target(f_tgt), .f_hist(f_hist), .f_kind(f_kind),
    .d_pc(dec_pc), .d_hit(d_hit),
    .u_valid(upd_valid), .u_pc(upd_pc), .u_taken(upd_taken), .u_kind(u_kind_e),
    .u_target(upd_target), .u_hit(u_hit), .u_hist(u_hist)
  );

  logic pht_wr;
  assign pht_wr = upd_valid && u_hit && (u_kind_e == K_COND);

  bpred_pht #(.HIST_W(HIST_W)) u_pht (
    .clk(clk), .rst_n(rst_int_n),
    .rd_idx(f_hist), .rd_taken(ctr_taken),
    .wr_en(pht_wr), .wr_idx(u_hist), .wr_taken(upd_taken)
  );

  // fetch-side decision
  logic is_call, is_ret, use_ras, ras_push, ras_pop;

  always_comb begin
    is_call       = f_hit && (f_kind == K_CALL);
    is_ret        = f_hit && (f_kind == K_RET);
    use_ras       = is_ret && ras_valid;
    pred_hit      = f_hit;
    pred_taken    = f_hit && ((f_kind == K_COND) ? ctr_taken : 1'b1);
    pred_from_ras = use_ras;
    pred_bubble   = pred_taken;
    if (!pred_taken)  pred_target = fetch_pc + STEP;
    else if (use_ras) pred_target = ras_top;
    else              pred_target = f_tgt;
    ras_push      = fetch_valid && is_call;
    ras_pop       = fetch_valid && use_ras;
  end

  bpred_ras #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk(clk), .rst_n(rst_int_n),
    .push(ras_push), .push_addr(fetch_pc + STEP),
    .pop(ras_pop), .top_valid(ras_valid), .top_addr(ras_top)
  );

  // decode-side static rule for buffer misses
  always_comb begin
    late_static   = dec_valid && !d_hit;
    late_taken    = late_static && (dec_target < dec_pc);
    late_redirect = late_taken;
    late_target   = late_taken ? dec_target : dec_pc + STEP;
  end

endmodule

// File: rtl/bpred_fetch_chk.sv
module bpred_fetch_chk #(
  parameter int PC_W       = 32,
  parameter int INSN_BYTES = 4
) (
  input logic            clk,
  input logic            rst_q_n,
  input logic            pred_hit,
  input logic            pred_taken,
  input logic [PC_W-1:0] pred_target,
  input logic            pred_from_ras,
  input logic [PC_W-1:0] fetch_pc,
  input logic            dec_valid,
  input logic [PC_W-1:0] dec_pc,
  input logic [PC_W-1:0] dec_target,
  input logic            late_redirect,
  input logic            late_static,
  input logic            upd_valid,
  input logic            upd_taken,
  input logic [PC_W-1:0] upd_pc
);

  // R1: a miss falls through sequentially
  p_miss_seq_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    !pred_hit |-> (!pred_taken && pred_target == fetch_pc + PC_W'(INSN_BYTES)));

  // R2: a taken resolution makes that address hit next cycle
  p_alloc_taken_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (upd_valid && upd_taken && fetch_pc == upd_pc) |=> ($stable(fetch_pc) -> pred_hit));

  // R2: a not-taken resolution of a miss allocates nothing
  p_no_alloc_nt_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (upd_valid && !upd_taken && !pred_hit && fetch_pc == upd_pc)
      |=> ($stable(fetch_pc) -> !pred_hit));

  // R5: late redirects only for backward targets of decoded misses
  p_late_backward_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    late_redirect |-> (dec_valid && late_static && dec_target < dec_pc));

  // R7: stack targets only come with a taken hit
  p_ras_taken_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    pred_from_ras |-> (pred_hit && pred_taken));

endmodule

bind bpred_fetch bpred_fetch_chk #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES)) u_chk (
  .clk(clk), .rst_q_n(rst_int_n),
  .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
  .pred_from_ras(pred_from_ras), .fetch_pc(fetch_pc),
  .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_target(dec_target),
  .late_redirect(late_redirect), .late_static(late_static),
  .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_pc(upd_pc)
);

// File: tb/sim_bpred_fetch.sv
module sim_bpred_fetch;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid;
  logic [31:0] fetch_pc;
  logic        pred_hit, pred_taken, pred_bubble, pred_from_ras;
  logic [31:0] pred_target;
  logic        dec_valid;
  logic [31:0] dec_pc, dec_target;
  logic        late_static, late_taken, late_redirect;
  logic [31:0] late_target;
  logic        upd_valid, upd_taken;
  logic [31:0] upd_pc, upd_target;
  logic [1:0]  upd_kind;

  always #(CLK_PERIOD/2) clk = ~clk;

  bpred_fetch u0 (.*);

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    finish_run();
  end

  task automatic do_fetch(input string req, input logic [31:0] pc,
                          input logic eh, input logic et, input logic [31:0] etg);
    @(negedge clk);
    fetch_pc = pc; fetch_valid = 1'b1;
    #1;
    chk({req, " hit"}, {31'd0, pred_hit}, {31'd0, eh});
    chk({req, " taken"}, {31'd0, pred_taken}, {31'd0, et});
    chk({req, " bubble"}, {31'd0, pred_bubble}, {31'd0, et});
    chk({req, " target"}, pred_target, etg);
    @(posedge clk); #1 fetch_valid = 1'b0;
  endtask

  task automatic do_upd(input logic [31:0] pc, input logic tk,
                        input logic [1:0] kind, input logic [31:0] tgt);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_kind = kind; upd_target = tgt;
    @(posedge clk); #1 upd_valid = 1'b0;
  endtask

  task automatic do_dec(input string req, input logic [31:0] pc, input logic [31:0] tgt,
                        input logic es, input logic er, input logic [31:0] etg);
    @(negedge clk);
    dec_valid = 1'b1; dec_pc = pc; dec_target = tgt;
    #1;
    chk({req, " static"}, {31'd0, late_static}, {31'd0, es});
    chk({req, " redirect"}, {31'd0, late_redirect}, {31'd0, er});
    chk({req, " ltaken"}, {31'd0, late_taken}, {31'd0, er});
    chk({req, " ltarget"}, late_target, etg);
    @(posedge clk); #1 dec_valid = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0]  op;     // 0 fetch, 1 update, 2 decode
    logic [31:0] pc;
    logic [31:0] tgt;
    logic        tk;
    logic [1:0]  kind;
    logic        ea;
    logic        eb;
    logic [31:0] etg;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VT [NV] = '{
    '{2'd0, 32'h1000, 32'h0,    1'b0, 2'd0, 1'b0, 1'b0, 32'h1004, 4'd1}, // R1
    '{2'd1, 32'h1000, 32'h0F00, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0,    4'd2}, // R2 nt miss
    '{2'd0, 32'h1000, 32'h0,    1'b0, 2'd0, 1'b0, 1'b0, 32'h1004, 4'd2}, // R2
    '{2'd1, 32'h1000, 32'h0F00, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0,    4'd2}, // R2 alloc
    '{2'd0, 32'h1000, 32'h0,    1'b0, 2'd0, 1'b1, 1'b0, 32'h1004, 4'd3}, // R3
    '{2'd1, 32'h1000, 32'h0F00, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0,    4'd4}, // R4
    '{2'd1, 32'h1000, 32'h0F00, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0,    4'd4},
    '{2'd1, 32'h1000, 32'h0F00, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0,    4'd4},
    '{2'd1, 32'h1000, 32'h0F00, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0,    4'd4},
    '{2'd0, 32'h1000, 32'h0,    1'b0, 2'd0, 1'b1, 1'b1, 32'h0F00, 4'd4}, // R4 taken
    '{2'd1, 32'h1000, 32'h0F00, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0,    4'd4},
    '{2'd0, 32'h1000, 32'h0,    1'b0, 2'd0, 1'b1, 1'b0, 32'h1004, 4'd4}, // R4 back to nt
    '{2'd2, 32'h2000, 32'h1F00, 1'b0, 2'd0, 1'b1, 1'b1, 32'h1F00, 4'd5}, // R5 backward
    '{2'd2, 32'h2000, 32'h2100, 1'b0, 2'd0, 1'b1, 1'b0, 32'h2004, 4'd5}, // R5 forward
    '{2'd2, 32'h1000, 32'h0F00, 1'b0, 2'd0, 1'b0, 1'b0, 32'h1004, 4'd5}, // R5 hit quiet
    '{2'd0, 32'h1100, 32'h0,    1'b0, 2'd0, 1'b0, 1'b0, 32'h1104, 4'd6}, // R6 alias
    '{2'd1, 32'h3040, 32'h5000, 1'b1, 2'd1, 1'b0, 1'b0, 32'h0,    4'd7}, // call
    '{2'd1, 32'h5010, 32'h6000, 1'b1, 2'd2, 1'b0, 1'b0, 32'h0,    4'd8}, // return
    '{2'd0, 32'h5010, 32'h0,    1'b0, 2'd0, 1'b1, 1'b1, 32'h6000, 4'd8}, // R8 empty
    '{2'd0, 32'h3040, 32'h0,    1'b0, 2'd0, 1'b1, 1'b1, 32'h5000, 4'd9}, // R9 call taken
    '{2'd0, 32'h5010, 32'h0,    1'b0, 2'd0, 1'b1, 1'b1, 32'h3044, 4'd7}, // R7 pop
    '{2'd0, 32'h5010, 32'h0,    1'b0, 2'd0, 1'b1, 1'b1, 32'h6000, 4'd8}, // R8 empty again
    '{2'd1, 32'h4000, 32'h4800, 1'b1, 2'd3, 1'b0, 1'b0, 32'h0,    4'd9}, // jump alloc
    '{2'd0, 32'h4000, 32'h0,    1'b0, 2'd0, 1'b1, 1'b1, 32'h4800, 4'd9}, // R9 jump
    '{2'd1, 32'h4000, 32'h7000, 1'b0, 2'd3, 1'b0, 1'b0, 32'h0,    4'd9},
    '{2'd0, 32'h4000, 32'h0,    1'b0, 2'd0, 1'b1, 1'b1, 32'h4800, 4'd9}, // R9 target kept
    '{2'd0, 32'h1000, 32'h0,    1'b0, 2'd0, 1'b0, 1'b0, 32'h1004, 4'd6}  // R6 replaced
  };

  initial begin
    rst_n = 1'b0; fetch_valid = 1'b0; fetch_pc = 32'h1000;
    dec_valid = 1'b0; dec_pc = '0; dec_target = '0;
    upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0; upd_kind = 2'd0; upd_target = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state at ports
    @(negedge clk); fetch_pc = 32'h5010; #1;
    chk("R1 reset hit", {31'd0, pred_hit}, 32'd0);
    chk("R1 reset target", pred_target, 32'h5014);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", VT[i].req, i);
      case (VT[i].op)
        2'd0: do_fetch(tag, VT[i].pc, VT[i].ea, VT[i].eb, VT[i].etg);
        2'd1: do_upd(VT[i].pc, VT[i].tk, VT[i].kind, VT[i].tgt);
        default: do_dec(tag, VT[i].pc, VT[i].tgt, VT[i].ea, VT[i].eb, VT[i].etg);
      endcase
    end

    // R7 stack overflow wraps: ten calls, newest eight survive
    for (int k = 1; k < 10; k++) do_upd(32'h3040 + 32'(4*k), 1'b1, 2'd1, 32'h5000);
    for (int k = 0; k < 10; k++) do_fetch("R7 call", 32'h3040 + 32'(4*k), 1'b1, 1'b1, 32'h5000);
    for (int k = 9; k >= 2; k--) begin
      @(negedge clk); fetch_pc = 32'h5010; #1;
      chk("R7 ras flag", {31'd0, pred_from_ras}, 32'd1);
      do_fetch("R7 wrap pop", 32'h5010, 1'b1, 1'b1, 32'h3044 + 32'(4*k));
    end
    @(negedge clk); fetch_pc = 32'h5010; #1;
    chk("R8 ras flag", {31'd0, pred_from_ras}, 32'd0);
    do_fetch("R8 drained", 32'h5010, 1'b1, 1'b1, 32'h6000);

    // R1 reset mid-run clears the buffer
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    do_fetch("R1 after reset", 32'h5010, 1'b0, 1'b0, 32'h5014);
    do_fetch("R1 after reset 2", 32'h4000, 1'b0, 1'b0, 32'h4004);

    finish_run();
  end

endmodule